// File: doc/BRIEF.md
# Four-Channel DMA Start and Completion Sequencer

This block owns the programming state of four DMA channels and decides when each one is launched and how it is retired. Every channel holds a 16-bit control word, a source address, a destination address and a word count, all loaded through one register write port. A channel is launched when its selected start condition occurs. The conditions are an immediate start when the channel is switched on, a horizontal-blank event, a vertical-blank event, or a special event tied to the channel's position. On the last channel the special event is a display-start window over a range of scan lines. On the middle channels it is a low-watermark request from an audio FIFO. On channel 0 the special event does not exist.

A launch appears on a one-cycle start strobe, together with the latched working source, destination and remaining count. The word transfer engine and the arbitration between channels sit outside this block. The engine reports the end of a transfer on a one-cycle done pulse per channel. Neither side applies back-pressure: start and done are plain pulses, and a done pulse is only acted on while the channel has a transfer in flight. When a transfer is retired, the block decides whether the channel stays enabled, reloads its working destination and raises a completion interrupt.

The line number and the blank pulses come in as inputs from the display timing logic. The number of visible lines is a parameter, 160 by default.

Top module: `dma_trigger_ctrl`

## Requirements
- R1: After reset every start strobe, interrupt, working count, working address, effective mode output and control readback is zero.
- R2: Writing the control word with enable (bit 15) going from 0 to 1 copies the programmed source and destination into the working addresses. If the start timing field (bits 13:12) is 0 (immediate), the start strobe rises exactly 3 clock edges after the write edge, with the working count equal to the programmed count.
- R3: A channel with timing 2 (horizontal blank) is armed by a horizontal-blank pulse only while the line input is below the visible line count.
- R4: A channel with timing 1 (vertical blank) is armed by each vertical-blank pulse. Its start strobe comes 3 edges after that pulse.
- R5: On channel 3 with timing 3, a horizontal-blank pulse arms the channel only for lines 2 through the visible line count plus 1, both inclusive.
- R6: A trigger has no effect when the channel is disabled, when its timing field selects a different event, or when a transfer is still armed or running. In the last case the working count keeps its value.
- R7: Timing 3 on channel 0 never starts a transfer.
- R8: On channels 1 and 2, timing 3 arms the channel on that channel's audio low-watermark input with a working count of 4, whatever the programmed count. While this mode is selected the effective destination mode reads 2 (fixed) and the effective width reads 1 (32-bit).
- R9: On completion the enable bit is cleared if repeat (bit 9) is 0, or if timing is 0, or if the channel is channel 3 with timing 3. Otherwise it stays set. The working count returns to 0.
- R10: On completion, destination mode 3 (bits 6:5) reloads the working destination from the programmed destination. Any other mode leaves the working destination unchanged.
- R11: On completion, a one-cycle interrupt pulse is raised on the edge after the done pulse if bit 14 is set.
- R12: The start strobe lasts exactly one cycle. A done pulse on a channel with no transfer running changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_ch_i | input | 2 | Channel addressed by the write |
| wr_sel_i | input | 2 | Register select: 0 control, 1 source, 2 destination, 3 count |
| wr_data_i | input | 32 | Write data (the control word uses bits 15:0) |
| line_i | input | 9 | Current scan line number |
| hblank_i | input | 1 | One-cycle horizontal-blank pulse |
| vblank_i | input | 1 | One-cycle vertical-blank pulse |
| aud_low_i | input | 2 | Audio FIFO low-watermark requests for channels 1 and 2 |
| done_i | input | 4 | Per-channel transfer-done pulse from the engine |
| start_o | output | 4 | Per-channel one-cycle start strobe |
| next_src_o | output | 128 | Working source address, 32 bits per channel |
| next_dst_o | output | 128 | Working destination address, 32 bits per channel |
| next_cnt_o | output | 64 | Remaining count, 16 bits per channel |
| eff_dst_mode_o | output | 8 | Effective destination mode, 2 bits per channel |
| eff_wide_o | output | 4 | Effective 32-bit width flag per channel |
| ctrl_rd_o | output | 64 | Control word readback, 16 bits per channel |
| irq_o | output | 4 | Per-channel completion interrupt pulse |

## Verification
The trigger logic is first tried with single events on single channels. These show the exact three-edge launch delay and which fields are latched at launch. Next, one whole frame is run with channel 1 on horizontal blank, channel 2 on vertical blank and channel 3 on display start all at once. The per-channel start counts (160, 1 and 1) then separate the line gating of R3 from the one-shot clearing of R9. A sweep of single horizontal-blank pulses at lines 0, 1, 2, 100, 161 and 162 marks both edges of the display-start window. Finally, triggers are sent to disabled, mismatched and busy channels, and done pulses to idle channels. Each of these must leave the outputs unchanged.

// File: rtl/dtc_pkg.sv
package dtc_pkg;
  typedef enum logic [1:0] {
    TM_IMM = 2'd0,
    TM_VBL = 2'd1,
    TM_HBL = 2'd2,
    TM_SPC = 2'd3
  } timing_e;

  typedef enum logic [1:0] {
    AC_INC = 2'd0,
    AC_DEC = 2'd1,
    AC_FIX = 2'd2,
    AC_RLD = 2'd3
  } addr_mode_e;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_SRC  = 2'd1,
    SEL_DST  = 2'd2,
    SEL_CNT  = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    CK_PLAIN = 2'd0,
    CK_AUDIO = 2'd1,
    CK_DISP  = 2'd2
  } chan_kind_e;

  localparam int CTL_W    = 16;
  localparam int B_DST_LO = 5;
  localparam int B_DST_HI = 6;
  localparam int B_REP    = 9;
  localparam int B_WIDE   = 10;
  localparam int B_TIM_LO = 12;
  localparam int B_TIM_HI = 13;
  localparam int B_IRQ    = 14;
  localparam int B_EN     = 15;
endpackage

// File: rtl/dtc_line_events.sv
module dtc_line_events #(
  parameter int LW       = 9,
  parameter int VIS      = 160,
  parameter int DS_FIRST = 2
) (
  input  logic [LW-1:0] line_i,
  input  logic          hblank_i,
  input  logic          vblank_i,
  output logic          hb_evt_o,
  output logic          vb_evt_o,
  output logic          ds_evt_o
);
  localparam logic [LW-1:0] VIS_L   = LW'(VIS);
  localparam logic [LW-1:0] DS_LO_L = LW'(DS_FIRST);
  localparam logic [LW-1:0] DS_HI_L = LW'(VIS + DS_FIRST - 1);

  always_comb begin
    hb_evt_o = hblank_i && (line_i < VIS_L);
    vb_evt_o = vblank_i;
    ds_evt_o = hblank_i && (line_i >= DS_LO_L) && (line_i <= DS_HI_L);
  end
endmodule

// File: rtl/dtc_channel.sv
module dtc_channel
  import dtc_pkg::*;
#(
  parameter dtc_pkg::chan_kind_e KIND = dtc_pkg::CK_PLAIN,
  parameter int DW        = 32,
  parameter int CW        = 16,
  parameter int START_LAT = 3,
  parameter int BURST     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  reg_sel_e         wr_sel_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic             hb_evt_i,
  input  logic             vb_evt_i,
  input  logic             spec_evt_i,
  input  logic             done_i,
  output logic             start_o,
  output logic [DW-1:0]    next_src_o,
  output logic [DW-1:0]    next_dst_o,
  output logic [CW-1:0]    next_cnt_o,
  output logic [1:0]       eff_dst_mode_o,
  output logic             eff_wide_o,
  output logic [CTL_W-1:0] ctrl_o,
  output logic             irq_o
);
  localparam int DLY_W = $clog2(START_LAT + 1);

  logic [CTL_W-1:0] ctrl_q;
  logic [DW-1:0]    src_q, dst_q, nsrc_q, ndst_q;
  logic [CW-1:0]    cnt_q, ncnt_q;
  logic [DLY_W-1:0] dly_q;
  logic             waiting_q, running_q, start_q, irq_q;

  timing_e    tim, wr_tim;
  addr_mode_e dmode;
  logic       wr_ctrl, en_rise, en_drop, busy, arm_imm, trig, finish, drop_en;
  logic [CW-1:0] load_cnt;

  always_comb begin
    tim     = timing_e'(ctrl_q[B_TIM_HI:B_TIM_LO]);
    wr_tim  = timing_e'(wr_data_i[B_TIM_HI:B_TIM_LO]);
    dmode   = addr_mode_e'(ctrl_q[B_DST_HI:B_DST_LO]);
    wr_ctrl = wr_en_i && (wr_sel_i == SEL_CTRL);
    en_rise = wr_ctrl && wr_data_i[B_EN] && !ctrl_q[B_EN];
    en_drop = wr_ctrl && !wr_data_i[B_EN];
    busy    = waiting_q || running_q;
    arm_imm = en_rise && (wr_tim == TM_IMM);
    trig    = 1'b0;
    if (ctrl_q[B_EN] && !busy && !wr_ctrl) begin
      unique case (tim)
        TM_HBL:  trig = hb_evt_i;
        TM_VBL:  trig = vb_evt_i;
        TM_SPC:  trig = (KIND != CK_PLAIN) && spec_evt_i;
        default: trig = 1'b0;
      endcase
    end
    load_cnt = ((KIND == CK_AUDIO) && (tim == TM_SPC) && !arm_imm) ? CW'(BURST) : cnt_q;
    finish   = done_i && running_q;
    drop_en  = !ctrl_q[B_REP] || (tim == TM_IMM) ||
               ((KIND == CK_DISP) && (tim == TM_SPC));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      src_q     <= '0;
      dst_q     <= '0;
      cnt_q     <= '0;
      nsrc_q    <= '0;
      ndst_q    <= '0;
      ncnt_q    <= '0;
      dly_q     <= '0;
      waiting_q <= 1'b0;
      running_q <= 1'b0;
      start_q   <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      start_q <= 1'b0;
      irq_q   <= 1'b0;
      if (wr_en_i) begin
        unique case (wr_sel_i)
          SEL_CTRL: ctrl_q <= wr_data_i[CTL_W-1:0];
          SEL_SRC:  src_q  <= wr_data_i;
          SEL_DST:  dst_q  <= wr_data_i;
          SEL_CNT:  cnt_q  <= wr_data_i[CW-1:0];
          default:  ;
        endcase
      end
      if (en_rise) begin
        nsrc_q <= src_q;
        ndst_q <= dst_q;
      end
      if (en_drop) begin
        waiting_q <= 1'b0;
        running_q <= 1'b0;
        ncnt_q    <= '0;
      end else if (arm_imm || trig) begin
        waiting_q <= 1'b1;
        dly_q     <= DLY_W'(START_LAT);
        ncnt_q    <= load_cnt;
      end else if (waiting_q) begin
        if (dly_q == DLY_W'(1)) begin
          waiting_q <= 1'b0;
          running_q <= 1'b1;
          start_q   <= 1'b1;
        end else begin
          dly_q <= dly_q - DLY_W'(1);
        end
      end else if (finish) begin
        running_q <= 1'b0;
        ncnt_q    <= '0;
        if (drop_en && !wr_ctrl) ctrl_q[B_EN] <= 1'b0;
        if (dmode == AC_RLD) ndst_q <= dst_q;
        irq_q <= ctrl_q[B_IRQ];
      end
    end
  end

  generate
    if (KIND == CK_AUDIO) begin : g_audio
      always_comb begin
        eff_dst_mode_o = (tim == TM_SPC) ? AC_FIX : dmode;
        eff_wide_o     = (tim == TM_SPC) ? 1'b1 : ctrl_q[B_WIDE];
      end
    end else begin : g_plain
      always_comb begin
        eff_dst_mode_o = dmode;
        eff_wide_o     = ctrl_q[B_WIDE];
      end
    end
  endgenerate

  assign start_o    = start_q;
  assign irq_o      = irq_q;
  assign next_src_o = nsrc_q;
  assign next_dst_o = ndst_q;
  assign next_cnt_o = ncnt_q;
  assign ctrl_o     = ctrl_q;

  // R12: the launch strobe never stretches past one cycle
  assert_start_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q);

  // R2: a launch always ends an armed wait and leaves the channel running
  assert_start_after_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> ($past(waiting_q) && !waiting_q && running_q));

  // R9: retiring a non-repeating transfer drops the enable bit
  assert_oneshot_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && running_q && !waiting_q && !wr_en_i && !ctrl_q[B_REP]) |=> !ctrl_q[B_EN]);

  // R11: an interrupt pulse only follows a retired transfer with the request bit set
  assert_irq_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(done_i && running_q && ctrl_q[B_IRQ]));
endmodule

// File: rtl/dma_trigger_ctrl.sv
module dma_trigger_ctrl
  import dtc_pkg::*;
#(
  parameter int NCH       = 4,
  parameter int DW        = 32,
  parameter int CW        = 16,
  parameter int LW        = 9,
  parameter int VIS       = 160,
  parameter int DS_FIRST  = 2,
  parameter int START_LAT = 3,
  parameter int BURST     = 4,
  localparam int CHW      = $clog2(NCH),
  localparam int NAUD     = NCH - 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en_i,
  input  logic [CHW-1:0]     wr_ch_i,
  input  logic [1:0]         wr_sel_i,
  input  logic [DW-1:0]      wr_data_i,
  input  logic [LW-1:0]      line_i,
  input  logic               hblank_i,
  input  logic               vblank_i,
  input  logic [NAUD-1:0]    aud_low_i,
  input  logic [NCH-1:0]     done_i,
  output logic [NCH-1:0]     start_o,
  output logic [NCH*DW-1:0]  next_src_o,
  output logic [NCH*DW-1:0]  next_dst_o,
  output logic [NCH*CW-1:0]  next_cnt_o,
  output logic [NCH*2-1:0]   eff_dst_mode_o,
  output logic [NCH-1:0]     eff_wide_o,
  output logic [NCH*CTL_W-1:0] ctrl_rd_o,
  output logic [NCH-1:0]     irq_o
);
  logic hb_evt, vb_evt, ds_evt;
  logic [NCH-1:0] spec_evt;
  reg_sel_e sel;

  assign sel = reg_sel_e'(wr_sel_i);

  dtc_line_events #(.LW(LW), .VIS(VIS), .DS_FIRST(DS_FIRST)) u_events (
    .line_i   (line_i),
    .hblank_i (hblank_i),
    .vblank_i (vblank_i),
    .hb_evt_o (hb_evt),
    .vb_evt_o (vb_evt),
    .ds_evt_o (ds_evt)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam chan_kind_e K = (c == NCH - 1) ? CK_DISP :
                               (c == 0)       ? CK_PLAIN : CK_AUDIO;
    if (c == NCH - 1) begin : g_disp
      assign spec_evt[c] = ds_evt;
    end else if (c == 0) begin : g_none
      assign spec_evt[c] = 1'b0;
    end else begin : g_aud
      assign spec_evt[c] = aud_low_i[c-1];
    end

    dtc_channel #(
      .KIND(K), .DW(DW), .CW(CW), .START_LAT(START_LAT), .BURST(BURST)
    ) u_ch (
      .clk            (clk),
      .rst_n          (rst_n),
      .wr_en_i        (wr_en_i && (wr_ch_i == CHW'(c))),
      .wr_sel_i       (sel),
      .wr_data_i      (wr_data_i),
      .hb_evt_i       (hb_evt),
      .vb_evt_i       (vb_evt),
      .spec_evt_i     (spec_evt[c]),
      .done_i         (done_i[c]),
      .start_o        (start_o[c]),
      .next_src_o     (next_src_o[c*DW +: DW]),
      .next_dst_o     (next_dst_o[c*DW +: DW]),
      .next_cnt_o     (next_cnt_o[c*CW +: CW]),
      .eff_dst_mode_o (eff_dst_mode_o[c*2 +: 2]),
      .eff_wide_o     (eff_wide_o[c]),
      .ctrl_o         (ctrl_rd_o[c*CTL_W +: CTL_W]),
      .irq_o          (irq_o[c])
    );
  end
endmodule

// File: tb/sim_dma_trigger_ctrl.sv
module sim_dma_trigger_ctrl;
  localparam int NCH = 4;
  localparam int DW  = 32;
  localparam int CW  = 16;
  localparam int LW  = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_ch = '0;
  logic [1:0] wr_sel = '0;
  logic [DW-1:0] wr_data = '0;
  logic [LW-1:0] line = '0;
  logic hblank = 1'b0, vblank = 1'b0;
  logic [1:0] aud_low = '0;
  logic [NCH-1:0] man_dn = '0, auto_dn = '0;
  logic [NCH-1:0] start, eff_wide, irq;
  logic [NCH*DW-1:0] nsrc, ndst;
  logic [NCH*CW-1:0] ncnt;
  logic [NCH*2-1:0] edm;
  logic [NCH*16-1:0] ctrl_rd;

  int n_chk = 0, n_bad = 0;
  int starts [NCH];
  int pend [NCH];
  bit auto_done = 0;

  always #10 clk = ~clk;

  dma_trigger_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_ch_i(wr_ch), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .line_i(line), .hblank_i(hblank), .vblank_i(vblank),
    .aud_low_i(aud_low), .done_i(man_dn | auto_dn), .start_o(start),
    .next_src_o(nsrc), .next_dst_o(ndst), .next_cnt_o(ncnt),
    .eff_dst_mode_o(edm), .eff_wide_o(eff_wide), .ctrl_rd_o(ctrl_rd), .irq_o(irq)
  );

  initial for (int c = 0; c < NCH; c++) begin starts[c] = 0; pend[c] = 0; end

  always @(negedge clk) begin
    for (int c = 0; c < NCH; c++) begin
      auto_dn[c] = 1'b0;
      if (pend[c] == 1) auto_dn[c] = 1'b1;
      if (pend[c] != 0) pend[c]--;
      if (start[c]) begin
        starts[c]++;
        if (auto_done) pend[c] = 2;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int ch, input int sel, input logic [31:0] d);
    wr_en = 1'b1; wr_ch = 2'(ch); wr_sel = 2'(sel); wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic done_pulse(input int ch);
    man_dn[ch] = 1'b1;
    tick();
    man_dn[ch] = 1'b0;
  endtask

  task automatic hb_pulse(input int ln);
    line = LW'(ln); hblank = 1'b1;
    tick();
    hblank = 1'b0;
  endtask

  function automatic logic [15:0] ctl(input int c); return ctrl_rd[c*16 +: 16]; endfunction
  function automatic logic [15:0] cnt(input int c); return ncnt[c*CW +: CW]; endfunction

  task automatic t_reset;
    chk("R1 start", 32'(start), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 ctrl", 32'(ctrl_rd[31:0] | ctrl_rd[63:32]), 0);
    chk("R1 cnt", 32'(ncnt[31:0] | ncnt[63:32]), 0);
    chk("R1 addr", nsrc[31:0] | ndst[127:96], 0);
    chk("R1 eff", 32'({edm, eff_wide}), 0);
  endtask

  task automatic t_immediate;
    wr(0, 1, 32'h100); wr(0, 2, 32'h200); wr(0, 3, 32'd8);
    wr(0, 0, 32'hC200);
    chk("R2 no start at edge 0", 32'(start[0]), 0);
    tick(); chk("R2 no start at edge 1", 32'(start[0]), 0);
    tick(); chk("R2 no start at edge 2", 32'(start[0]), 0);
    tick(); chk("R2 start at edge 3", 32'(start[0]), 1);
    chk("R2 count", 32'(cnt(0)), 8);
    chk("R2 src", nsrc[31:0], 32'h100);
    chk("R2 dst", ndst[31:0], 32'h200);
    tick(); chk("R12 strobe one cycle", 32'(start[0]), 0);
    done_pulse(0);
    chk("R11 irq", 32'(irq[0]), 1);
    chk("R9 immediate clears enable despite repeat", 32'(ctl(0)[15]), 0);
    chk("R9 count zero", 32'(cnt(0)), 0);
    tick(); chk("R11 irq one cycle", 32'(irq[0]), 0);
  endtask

  task automatic t_reload;
    wr(2, 2, 32'h300); wr(2, 3, 32'd2); wr(2, 0, 32'h8060);
    tick(5);
    wr(2, 2, 32'h400);
    chk("R10 dst kept while running", ndst[95:64], 32'h300);
    done_pulse(2);
    chk("R10 reload dst", ndst[95:64], 32'h400);
    chk("R11 no irq without bit 14", 32'(irq[2]), 0);
    wr(0, 2, 32'h500); wr(0, 0, 32'h8000);
    tick(5);
    wr(0, 2, 32'h600);
    done_pulse(0);
    chk("R10 increment keeps dst", ndst[31:0], 32'h500);
  endtask

  task automatic t_ignored;
    int s1;
    wr(1, 3, 32'd4); wr(1, 0, 32'h2200);
    s1 = starts[1];
    hb_pulse(10); tick(6);
    chk("R6 disabled channel ignores trigger", 32'(starts[1] - s1), 0);
    wr(2, 0, 32'h9200);
    s1 = starts[2];
    hb_pulse(10); tick(6);
    chk("R6 mode mismatch ignored", 32'(starts[2] - s1), 0);
    wr(1, 0, 32'hA200);
    s1 = starts[1];
    hb_pulse(10); tick(6);
    chk("R3 hblank start", 32'(starts[1] - s1), 1);
    wr(1, 3, 32'd9);
    hb_pulse(11); tick(6);
    chk("R6 busy channel not rearmed", 32'(starts[1] - s1), 1);
    chk("R6 count unchanged", 32'(cnt(1)), 4);
    done_pulse(1);
    chk("R9 repeat keeps enable", 32'(ctl(1)[15]), 1);
    wr(1, 0, 32'h0); wr(2, 0, 32'h0);
  endtask

  task automatic t_ch0_special;
    int s0;
    wr(0, 3, 32'd5); wr(0, 0, 32'hB000);
    s0 = starts[0];
    hb_pulse(5); tick(2);
    hb_pulse(100); vblank = 1'b1; tick(); vblank = 1'b0; tick(6);
    chk("R7 channel 0 special never starts", 32'(starts[0] - s0), 0);
    chk("R7 count stays zero", 32'(cnt(0)), 0);
    wr(0, 0, 32'h0);
  endtask

  task automatic t_audio;
    int s1;
    wr(1, 3, 32'd16); wr(1, 0, 32'hF200);
    chk("R8 eff dst fixed", 32'(edm[3:2]), 2);
    chk("R8 eff wide", 32'(eff_wide[1]), 1);
    s1 = starts[1];
    aud_low[0] = 1'b1; tick(); aud_low[0] = 1'b0;
    tick(2); chk("R8 not yet started", 32'(start[1]), 0);
    tick(); chk("R8 start", 32'(start[1]), 1);
    chk("R8 burst count", 32'(cnt(1)), 4);
    tick(2);
    done_pulse(1);
    chk("R9 audio repeat keeps enable", 32'(ctl(1)[15]), 1);
    chk("R11 audio irq", 32'(irq[1]), 1);
    tick();
    done_pulse(1);
    chk("R12 idle done no irq", 32'(irq[1]), 0);
    chk("R12 idle done keeps enable", 32'(ctl(1)[15]), 1);
    chk("R12 single start", 32'(starts[1] - s1), 1);
    wr(1, 0, 32'h0);
  endtask

  task automatic t_frame;
    int s1, s2, s3;
    auto_done = 1;
    wr(1, 3, 32'd4); wr(1, 0, 32'hA200);
    wr(2, 3, 32'd4); wr(2, 0, 32'h9200);
    wr(3, 3, 32'd4); wr(3, 0, 32'hB200);
    s1 = starts[1]; s2 = starts[2]; s3 = starts[3];
    for (int ln = 0; ln < 228; ln++) begin
      hb_pulse(ln);
      tick(2);
      if (ln == 160) begin vblank = 1'b1; tick(); vblank = 1'b0; end
      tick(8);
    end
    chk("R3 hblank starts per frame", 32'(starts[1] - s1), 160);
    chk("R4 vblank starts per frame", 32'(starts[2] - s2), 1);
    chk("R9 display start one shot", 32'(starts[3] - s3), 1);
    chk("R9 display start enable cleared", 32'(ctl(3)[15]), 0);
    chk("R9 hblank repeat enable kept", 32'(ctl(1)[15]), 1);
    wr(1, 0, 32'h0); wr(2, 0, 32'h0);
    auto_done = 0;
  endtask

  task automatic t_window(input int ln, input int exp);
    int s3;
    auto_done = 1;
    wr(3, 0, 32'h0); wr(3, 0, 32'hB000);
    s3 = starts[3];
    hb_pulse(ln); tick(8);
    chk($sformatf("R5 display window line %0d", ln), 32'(starts[3] - s3), 32'(exp));
    wr(3, 0, 32'h0);
    auto_done = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick();
    t_reset();
    t_immediate();
    t_reload();
    t_ignored();
    t_ch0_special();
    t_audio();
    t_frame();
    t_window(0, 0);
    t_window(1, 0);
    t_window(2, 1);
    t_window(100, 1);
    t_window(161, 1);
    t_window(162, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule